// File: doc/BRIEF.md
# Partitioned Fully Associative Translation Buffer

This block is a fully associative translation buffer with a configurable number of entries, up to 64. Each entry holds a page-aligned virtual address, a two-bit page-size code, a partition number, a context number, a flag marking it as a real-address (untranslated-context) mapping, a lock flag and an opaque page-table data word. One lookup port searches every entry in the same cycle. It returns a hit flag, the index of the matching entry and that entry's data word.

One command can be issued per clock. The commands are: insert a mapping, remove one page, remove every mapping of a context, or remove every unlocked mapping of a partition. An insert first removes every existing entry that it would overlap. It then writes either to the index the caller names or to a slot picked from the valid, used and locked state. A per-entry used bit gives not-recently-used replacement. A readback port returns a packed tag word and the data word of any entry by index, so software-style table inspection and the test bench can see the stored state.

Commands and used-bit updates take effect at the next rising clock edge. The lookup and readback ports always reflect the contents from before that edge.

Top module: `tlb_assoc`

## Requirements
- R1: While reset is low, and after it rises, every entry is invalid and every used bit is clear. No lookup hits, and readback of any index returns all ones for both tag and data.
- R2: A lookup hits an entry only if all of these hold: the entry is valid, its real flag equals `lkReal`, its partition equals `lkPart`, and `lkVa` lies within its page. For entries whose real flag is 0, the context must also equal `lkCtx`; for real entries the context is not compared. On a hit, `lkIdx` and `lkData` give that entry's index and data. The result is combinational on the current contents, and a command in the same cycle does not change it.
- R3: Page-size codes 0, 1, 2 and 3 stand for pages of 2^13, 2^16, 2^22 and 2^28 bytes. On insert, the stored address is `cmdVa` with its offset bits (below the page size) cleared.
- R4: The insert command is `cmdOp` = 1. Before the new entry is written, every valid entry is invalidated and its used bit cleared if it meets all of these: same real flag, same partition, same context (context is compared only when `cmdReal` = 0), and an address range that overlaps the new page. Afterwards at most one entry matches any lookup.
- R5: The insert slot is picked by the first rule that applies. (1) If `cmdUseIdx` = 1, the slot is `cmdIdx`. (2) Otherwise, the lowest-index entry that is invalid after the overlap removal of R4. (3) Otherwise, the lowest-index unlocked entry whose used bit is clear. (4) Otherwise, the lowest-index unlocked entry. (5) If every entry is locked, entry NUM_ENTRIES-1.
- R6: Used bits are set for the inserted slot, and for the hit entry when `lkReq` = 1, unless that entry is invalidated in the same cycle. If the resulting used bits would all be set, only the bits just set remain set.
- R7: The demap-page command is `cmdOp` = 2. It invalidates the entry that `cmdVa`, `cmdPart`, `cmdCtx` and `cmdReal` would hit under the rule of R2, and clears its used bit.
- R8: The demap-context command is `cmdOp` = 3. It invalidates every valid entry whose partition equals `cmdPart` and whose context equals `cmdCtx`, whatever its real flag or lock.
- R9: The demap-all command is `cmdOp` = 4. It invalidates every valid entry of partition `cmdPart` whose lock flag is 0; locked entries stay valid. Codes 0, 5, 6 and 7 do nothing.
- R10: For a valid entry, the readback tag `rdTag` is built from these fields: context in bits [CTX_W-1:0], OR-ed with the stored aligned address in bits [VA_W-1:0]; partition starting at bit 61; real flag at bit 60; the inverted size code in bits 57:56; all other bits 0. `rdData` is the stored data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lkReq | input | 1 | Lookup is a real access; a hit updates the used bits |
| lkVa | input | VA_W | Lookup virtual address |
| lkPart | input | PART_W | Lookup partition |
| lkCtx | input | CTX_W | Lookup context |
| lkReal | input | 1 | Lookup is a real-address access |
| lkHit | output | 1 | Some entry matches |
| lkIdx | output | IDX_W | Index of the matching entry |
| lkData | output | DATA_W | Data word of the matching entry |
| cmdOp | input | 3 | 0 none, 1 insert, 2 demap page, 3 demap context, 4 demap all |
| cmdVa | input | VA_W | Command address |
| cmdPart | input | PART_W | Command partition |
| cmdCtx | input | CTX_W | Command context |
| cmdReal | input | 1 | Command real flag |
| cmdSize | input | 2 | Page-size code for insert |
| cmdLock | input | 1 | Lock flag for insert |
| cmdData | input | DATA_W | Data word for insert |
| cmdUseIdx | input | 1 | Insert goes to `cmdIdx` |
| cmdIdx | input | IDX_W | Explicit insert slot |
| rdIdx | input | IDX_W | Readback index |
| rdTag | output | 64 | Packed tag word of entry `rdIdx` |
| rdData | output | DATA_W | Data word of entry `rdIdx` |

## Verification
A corrupted valid bit, address or key field shows up at the ports in the same cycle. It appears as a wrong `lkHit` on the next lookup that touches that page, or as a wrong tag in readback. The readback index sweeps every slot, so any stored-field error is exposed within NUM_ENTRIES cycles. A wrong used or lock bit stays hidden until the next insert that picks its own slot with the table full. It then appears as the new mapping landing in the wrong index, which readback and lookup show one cycle after that insert.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int MAX_ENTRIES = 64;
  localparam int IDX_MAX_W   = 6;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_INSERT     = 3'd1,
    OP_DEMAP_PAGE = 3'd2,
    OP_DEMAP_CTX  = 3'd3,
    OP_DEMAP_ALL  = 3'd4
  } tlbOpE;

  // Strobes from control to datapath, applied at the next edge
  typedef struct packed {
    logic                   writeEn;
    logic [IDX_MAX_W-1:0]   writeIdx;
    logic [MAX_ENTRIES-1:0] invalVec;
  } tlbStrobeS;

  // log2 of the page size in bytes for each size code
  function automatic int unsigned pageShift(input logic [1:0] code);
    case (code)
      2'd0:    return 13;
      2'd1:    return 16;
      2'd2:    return 22;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 40,
  parameter int CTX_W       = 13,
  parameter int PART_W      = 3,
  parameter int DATA_W      = 64,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobeS              strobe,
  input  logic [VA_W-1:0]        lkVa,
  input  logic [PART_W-1:0]      lkPart,
  input  logic [CTX_W-1:0]       lkCtx,
  input  logic                   lkReal,
  input  logic [VA_W-1:0]        cmdVa,
  input  logic [PART_W-1:0]      cmdPart,
  input  logic [CTX_W-1:0]       cmdCtx,
  input  logic                   cmdReal,
  input  logic [1:0]             cmdSize,
  input  logic                   cmdLock,
  input  logic [DATA_W-1:0]      cmdData,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [NUM_ENTRIES-1:0] ovlVec,
  output logic [NUM_ENTRIES-1:0] pageVec,
  output logic [NUM_ENTRIES-1:0] ctxVec,
  output logic [NUM_ENTRIES-1:0] allVec,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] lockVec,
  output logic                   lkHit,
  output logic [IDX_W-1:0]       lkIdx,
  output logic [DATA_W-1:0]      lkData,
  output logic [63:0]            rdTag,
  output logic [DATA_W-1:0]      rdData
);

  function automatic logic [VA_W-1:0] spanMask(input logic [1:0] code);
    return (VA_W'(1) << pageShift(code)) - VA_W'(1);
  endfunction

  logic [NUM_ENTRIES-1:0] entValid;
  logic [VA_W-1:0]        entVa   [NUM_ENTRIES];
  logic [1:0]             entSize [NUM_ENTRIES];
  logic [PART_W-1:0]      entPart [NUM_ENTRIES];
  logic [CTX_W-1:0]       entCtx  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entReal;
  logic [NUM_ENTRIES-1:0] entLock;
  logic [DATA_W-1:0]      entData [NUM_ENTRIES];

  logic [VA_W-1:0] newMask, newVa;
  logic            unusedStrobeBits;

  assign newMask          = spanMask(cmdSize);
  assign newVa            = cmdVa & ~newMask;
  assign unusedStrobeBits = ^strobe.invalVec;

  // valid bits: write wins over invalidation of the same slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobe.writeEn && strobe.writeIdx == IDX_MAX_W'(i)) entValid[i] <= 1'b1;
        else if (strobe.invalVec[i])                            entValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (strobe.writeEn && strobe.writeIdx == IDX_MAX_W'(i)) begin
        entVa[i]   <= newVa;
        entSize[i] <= cmdSize;
        entPart[i] <= cmdPart;
        entCtx[i]  <= cmdCtx;
        entReal[i] <= cmdReal;
        entLock[i] <= cmdLock;
        entData[i] <= cmdData;
      end
    end
  end

  // per-entry comparators
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [VA_W-1:0] eMask;
    logic            lkKey, cmdKey;
    assign eMask  = spanMask(entSize[g]);
    assign lkKey  = entValid[g] && entReal[g] == lkReal && entPart[g] == lkPart &&
                    (entReal[g] || entCtx[g] == lkCtx);
    assign cmdKey = entValid[g] && entReal[g] == cmdReal && entPart[g] == cmdPart &&
                    (entReal[g] || entCtx[g] == cmdCtx);
    assign hitVec[g]  = lkKey && ((lkVa & ~eMask) == entVa[g]);
    assign pageVec[g] = cmdKey && ((cmdVa & ~eMask) == entVa[g]);
    assign ovlVec[g]  = cmdKey && (entVa[g] <= (newVa | newMask)) &&
                        ((entVa[g] | eMask) >= newVa);
    assign ctxVec[g]  = entValid[g] && entPart[g] == cmdPart && entCtx[g] == cmdCtx;
    assign allVec[g]  = entValid[g] && entPart[g] == cmdPart && !entLock[g];
  end

  assign validVec = entValid;
  assign lockVec  = entLock;

  always_comb begin
    lkIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) lkIdx = IDX_W'(i);
    end
  end

  assign lkHit  = |hitVec;
  assign lkData = entData[lkIdx];

  always_comb begin
    rdTag  = '1;
    rdData = '1;
    if (entValid[rdIdx]) begin
      rdTag                  = '0;
      rdTag[CTX_W-1:0]       = entCtx[rdIdx];
      rdTag[VA_W-1:0]        = rdTag[VA_W-1:0] | entVa[rdIdx];
      rdTag[61 +: PART_W]    = entPart[rdIdx];
      rdTag[60]              = entReal[rdIdx];
      rdTag[57:56]           = ~entSize[rdIdx];
      rdData                 = entData[rdIdx];
    end
  end

  // overlap removal keeps every lookup to at most one match
  assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // the slot written by an insert is valid afterwards
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeEn && int'(strobe.writeIdx) < NUM_ENTRIES)
      |=> entValid[$past(strobe.writeIdx[IDX_W-1:0])]);

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbOpE                  op,
  input  logic                   cmdUseIdx,
  input  logic [IDX_W-1:0]       cmdIdx,
  input  logic                   lkReq,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] ovlVec,
  input  logic [NUM_ENTRIES-1:0] pageVec,
  input  logic [NUM_ENTRIES-1:0] ctxVec,
  input  logic [NUM_ENTRIES-1:0] allVec,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] lockVec,
  output tlbStrobeS              strobe
);

  logic [NUM_ENTRIES-1:0] used, usedMid, usedNext;
  logic [NUM_ENTRIES-1:0] inval, freeVec, setVec;
  logic [IDX_W-1:0]       victim;
  logic                   found;

  always_comb begin
    inval = '0;
    case (op)
      OP_INSERT:     inval = ovlVec;
      OP_DEMAP_PAGE: inval = pageVec;
      OP_DEMAP_CTX:  inval = ctxVec;
      OP_DEMAP_ALL:  inval = allVec;
      default:       inval = '0;
    endcase
  end

  // victim: free, then unlocked and not used, then unlocked, then last
  always_comb begin
    freeVec = ~(validVec & ~inval);
    victim  = IDX_W'(NUM_ENTRIES - 1);
    found   = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && freeVec[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && !lockVec[i] && !used[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && !lockVec[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (cmdUseIdx) victim = cmdIdx;
  end

  always_comb begin
    strobe                          = '0;
    strobe.writeEn                  = (op == OP_INSERT);
    strobe.writeIdx                 = IDX_MAX_W'(victim);
    strobe.invalVec[NUM_ENTRIES-1:0] = inval;
  end

  always_comb begin
    setVec = '0;
    if (lkReq) setVec = hitVec & ~inval;
    if (op == OP_INSERT && int'(victim) < NUM_ENTRIES) setVec[victim] = 1'b1;
    usedMid  = (used & ~inval) | setVec;
    usedNext = (&usedMid) ? setVec : usedMid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) used <= '0;
    else       used <= usedNext;
  end

  if (NUM_ENTRIES > 1) begin : gSatCheck
    assert_used_never_full_R6: assert property (@(posedge clk) disable iff (!rstN)
      !(&used));
  end

  assert_insert_marks_used_R6: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_INSERT && int'(victim) < NUM_ENTRIES) |=> used[$past(victim)]);

  assert_lock_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_DEMAP_ALL) |=> (($past(validVec & lockVec) & ~validVec) == '0));

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 40,
  parameter int CTX_W       = 13,
  parameter int PART_W      = 3,
  parameter int DATA_W      = 64,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkReq,
  input  logic [VA_W-1:0]   lkVa,
  input  logic [PART_W-1:0] lkPart,
  input  logic [CTX_W-1:0]  lkCtx,
  input  logic              lkReal,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [DATA_W-1:0] lkData,
  input  logic [2:0]        cmdOp,
  input  logic [VA_W-1:0]   cmdVa,
  input  logic [PART_W-1:0] cmdPart,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic              cmdReal,
  input  logic [1:0]        cmdSize,
  input  logic              cmdLock,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdUseIdx,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [63:0]       rdTag,
  output logic [DATA_W-1:0] rdData
);

  tlbStrobeS              strobe;
  logic [NUM_ENTRIES-1:0] hitVec, ovlVec, pageVec, ctxVec, allVec, validVec, lockVec;
  tlbOpE                  op;

  assign op = tlbOpE'(cmdOp);

  tlb_control #(.NUM_ENTRIES(NUM_ENTRIES)) u_control (
    .clk(clk), .rstN(rstN), .op(op), .cmdUseIdx(cmdUseIdx), .cmdIdx(cmdIdx),
    .lkReq(lkReq), .hitVec(hitVec), .ovlVec(ovlVec), .pageVec(pageVec),
    .ctxVec(ctxVec), .allVec(allVec), .validVec(validVec), .lockVec(lockVec),
    .strobe(strobe)
  );

  tlb_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .CTX_W(CTX_W),
    .PART_W(PART_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkVa(lkVa), .lkPart(lkPart), .lkCtx(lkCtx), .lkReal(lkReal),
    .cmdVa(cmdVa), .cmdPart(cmdPart), .cmdCtx(cmdCtx), .cmdReal(cmdReal),
    .cmdSize(cmdSize), .cmdLock(cmdLock), .cmdData(cmdData), .rdIdx(rdIdx),
    .hitVec(hitVec), .ovlVec(ovlVec), .pageVec(pageVec), .ctxVec(ctxVec),
    .allVec(allVec), .validVec(validVec), .lockVec(lockVec),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkData(lkData), .rdTag(rdTag), .rdData(rdData)
  );

endmodule

// File: tb/test_tlb_assoc.sv
`timescale 1ns/1ps
module test_tlb_assoc;
  localparam int N      = 8;
  localparam int VA_W   = 40;
  localparam int CTX_W  = 13;
  localparam int PART_W = 3;
  localparam int DATA_W = 64;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              lkReq, lkReal, lkHit;
  logic [VA_W-1:0]   lkVa;
  logic [PART_W-1:0] lkPart;
  logic [CTX_W-1:0]  lkCtx;
  logic [IDX_W-1:0]  lkIdx;
  logic [DATA_W-1:0] lkData;
  logic [2:0]        cmdOp;
  logic [VA_W-1:0]   cmdVa;
  logic [PART_W-1:0] cmdPart;
  logic [CTX_W-1:0]  cmdCtx;
  logic              cmdReal, cmdLock, cmdUseIdx;
  logic [1:0]        cmdSize;
  logic [DATA_W-1:0] cmdData;
  logic [IDX_W-1:0]  cmdIdx, rdIdx;
  logic [63:0]       rdTag;
  logic [DATA_W-1:0] rdData;

  tlb_assoc #(.NUM_ENTRIES(N), .VA_W(VA_W), .CTX_W(CTX_W), .PART_W(PART_W),
              .DATA_W(DATA_W)) i_tlb_assoc (
    .clk(clk), .rstN(rstN), .lkReq(lkReq), .lkVa(lkVa), .lkPart(lkPart),
    .lkCtx(lkCtx), .lkReal(lkReal), .lkHit(lkHit), .lkIdx(lkIdx), .lkData(lkData),
    .cmdOp(cmdOp), .cmdVa(cmdVa), .cmdPart(cmdPart), .cmdCtx(cmdCtx),
    .cmdReal(cmdReal), .cmdSize(cmdSize), .cmdLock(cmdLock), .cmdData(cmdData),
    .cmdUseIdx(cmdUseIdx), .cmdIdx(cmdIdx), .rdIdx(rdIdx), .rdTag(rdTag),
    .rdData(rdData)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  // behavioural reference model
  bit                mVal  [N];
  logic [VA_W-1:0]   mVa   [N];
  logic [1:0]        mSize [N];
  logic [PART_W-1:0] mPart [N];
  logic [CTX_W-1:0]  mCtx  [N];
  bit                mRl   [N];
  bit                mLock [N];
  bit                mUsed [N];
  logic [63:0]       mData [N];

  function automatic logic [VA_W-1:0] spanOf(input logic [1:0] s);
    int sh;
    sh = (s == 2'd0) ? 13 : (s == 2'd1) ? 16 : (s == 2'd2) ? 22 : 28;
    return (VA_W'(1) << sh) - VA_W'(1);
  endfunction

  function automatic int findEntry(input logic [VA_W-1:0] va, input logic [PART_W-1:0] pt,
                                   input logic [CTX_W-1:0] cx, input bit rl);
    for (int i = 0; i < N; i++) begin
      if (mVal[i] && mRl[i] == rl && mPart[i] == pt && va >= mVa[i] &&
          va <= mVa[i] + spanOf(mSize[i]) && (rl || mCtx[i] == cx))
        return i;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compareOutputs(input string tag);
    int e;
    logic [63:0] t;
    e = findEntry(lkVa, lkPart, lkCtx, lkReal);
    check(tag, "lookup hit", 64'(lkHit), 64'(e >= 0));
    if (e >= 0) begin
      check(tag, "lookup index", 64'(lkIdx), 64'(e));
      check(tag, "lookup data", lkData, mData[e]);
    end
    if (!mVal[rdIdx]) begin
      check("R1", "readback tag", rdTag, '1);
      check("R1", "readback data", rdData, '1);
    end else begin
      t = 64'(mCtx[rdIdx]) | 64'(mVa[rdIdx]) | (64'(mPart[rdIdx]) << 61) |
          (64'(mRl[rdIdx]) << 60) | (64'(2'b11 ^ mSize[rdIdx]) << 56);
      check("R10", "readback tag", rdTag, t);
      check("R10", "readback data", rdData, mData[rdIdx]);
    end
  endtask

  task automatic updateModel();
    int hit, slot, cnt;
    bit inv [N];
    bit st  [N];
    logic [VA_W-1:0] al, msk;
    hit = lkReq ? findEntry(lkVa, lkPart, lkCtx, lkReal) : -1;
    for (int i = 0; i < N; i++) begin inv[i] = 0; st[i] = 0; end
    case (cmdOp)
      3'd1: begin
        msk = spanOf(cmdSize);
        al  = cmdVa & ~msk;
        for (int i = 0; i < N; i++)
          if (mVal[i] && mRl[i] == cmdReal && mPart[i] == cmdPart &&
              (cmdReal || mCtx[i] == cmdCtx) && mVa[i] <= al + msk &&
              mVa[i] + spanOf(mSize[i]) >= al) begin
            inv[i] = 1; mVal[i] = 0;
          end
        slot = -1;
        if (cmdUseIdx) slot = int'(cmdIdx);
        for (int i = 0; i < N; i++) if (slot < 0 && !mVal[i]) slot = i;
        for (int i = 0; i < N; i++) if (slot < 0 && !mLock[i] && !mUsed[i]) slot = i;
        for (int i = 0; i < N; i++) if (slot < 0 && !mLock[i]) slot = i;
        if (slot < 0) slot = N - 1;
        mVal[slot] = 1; mVa[slot] = al; mSize[slot] = cmdSize; mPart[slot] = cmdPart;
        mCtx[slot] = cmdCtx; mRl[slot] = cmdReal; mLock[slot] = cmdLock;
        mData[slot] = cmdData; st[slot] = 1;
      end
      3'd2: begin
        slot = findEntry(cmdVa, cmdPart, cmdCtx, cmdReal);
        if (slot >= 0) begin inv[slot] = 1; mVal[slot] = 0; end
      end
      3'd3: for (int i = 0; i < N; i++)
              if (mVal[i] && mPart[i] == cmdPart && mCtx[i] == cmdCtx) begin
                inv[i] = 1; mVal[i] = 0;
              end
      3'd4: for (int i = 0; i < N; i++)
              if (mVal[i] && mPart[i] == cmdPart && !mLock[i]) begin
                inv[i] = 1; mVal[i] = 0;
              end
      default: ;
    endcase
    if (hit >= 0 && !inv[hit]) st[hit] = 1;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      mUsed[i] = (mUsed[i] && !inv[i]) || st[i];
      if (mUsed[i]) cnt++;
    end
    if (cnt == N) for (int i = 0; i < N; i++) mUsed[i] = st[i];
  endtask

  task automatic step(input string tag);
    rdIdx = IDX_W'(cyc % N);
    cyc++;
    #1;
    compareOutputs(tag);
    @(posedge clk);
    if (rstN) updateModel();
    @(negedge clk);
  endtask

  task automatic look(input string tag, input logic [VA_W-1:0] va, input int pt,
                      input int cx, input bit rl, input bit req);
    lkVa = va; lkPart = PART_W'(pt); lkCtx = CTX_W'(cx); lkReal = rl; lkReq = req;
    step(tag);
    lkReq = 0;
  endtask

  task automatic ins(input string tag, input logic [VA_W-1:0] va, input int pt,
                     input int cx, input bit rl, input int sz, input bit lk,
                     input bit useIdx, input int idx);
    cmdOp = 3'd1; cmdVa = va; cmdPart = PART_W'(pt); cmdCtx = CTX_W'(cx);
    cmdReal = rl; cmdSize = 2'(sz); cmdLock = lk; cmdUseIdx = useIdx;
    cmdIdx = IDX_W'(idx); cmdData = {$urandom, $urandom};
    step(tag);
    cmdOp = 3'd0;
    step(tag);
  endtask

  task automatic demap(input string tag, input int kind, input logic [VA_W-1:0] va,
                       input int pt, input int cx, input bit rl);
    cmdOp = 3'(kind); cmdVa = va; cmdPart = PART_W'(pt); cmdCtx = CTX_W'(cx);
    cmdReal = rl;
    step(tag);
    cmdOp = 3'd0;
    step(tag);
  endtask

  initial begin
    #(8ns * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mVal[i] = 0; mUsed[i] = 0; mLock[i] = 0; end
    rstN = 0; lkReq = 0; lkVa = '0; lkPart = '0; lkCtx = '0; lkReal = 0;
    cmdOp = 0; cmdVa = '0; cmdPart = '0; cmdCtx = '0; cmdReal = 0; cmdSize = 0;
    cmdLock = 0; cmdData = '0; cmdUseIdx = 0; cmdIdx = '0; rdIdx = '0;
    @(negedge clk);
    // R1: reset state, no hits, readback all ones
    for (int k = 0; k < 4; k++) look("R1", VA_W'(k) << 13, 0, 0, 0, 1);
    rstN = 1;
    for (int k = 0; k < N; k++) look("R1", VA_W'(k) << 13, 0, 0, 0, 1);

    // R3: every page size, unaligned addresses, explicit slots
    ins("R3", 40'h0_0001_2345, 0, 1, 0, 0, 0, 1, 0);
    ins("R3", 40'h0_0004_1234, 0, 1, 0, 1, 0, 1, 1);
    ins("R3", 40'h0_0080_0777, 0, 1, 0, 2, 0, 1, 2);
    ins("R3", 40'h0_3000_0abc, 0, 5, 1, 3, 0, 1, 3);
    look("R3", 40'h0_0001_2000, 0, 1, 0, 1);
    look("R3", 40'h0_0001_3fff, 0, 1, 0, 1);
    look("R3", 40'h0_0001_4000, 0, 1, 0, 1);
    look("R3", 40'h0_0004_ffff, 0, 1, 0, 1);
    look("R3", 40'h0_0005_0000, 0, 1, 0, 1);
    look("R3", 40'h0_00bf_ffff, 0, 1, 0, 1);
    look("R3", 40'h0_3fff_ffff, 0, 9, 1, 1);
    // R2: key matching, context ignored for real entries
    look("R2", 40'h0_0001_2345, 0, 2, 0, 0);
    look("R2", 40'h0_0001_2345, 1, 1, 0, 0);
    look("R2", 40'h0_0001_2345, 0, 1, 1, 0);
    look("R2", 40'h0_3000_0000, 0, 0, 1, 0);
    look("R2", 40'h0_3000_0000, 0, 5, 0, 0);
    // R2: command in same cycle does not change the lookup result
    lkVa = 40'h0_0004_0000; lkPart = 0; lkCtx = 1; lkReal = 0;
    cmdOp = 3'd2; cmdVa = 40'h0_0004_0000; cmdPart = 0; cmdCtx = 1; cmdReal = 0;
    step("R2");
    cmdOp = 3'd0;
    step("R2");

    // R4: overlapping insert evicts the 8K page, other contexts untouched
    ins("R4", 40'h0_0001_0000, 0, 7, 0, 0, 0, 0, 0);
    ins("R4", 40'h0_0001_0000, 0, 1, 0, 1, 0, 0, 0);
    look("R4", 40'h0_0001_2345, 0, 1, 0, 1);
    look("R4", 40'h0_0001_0000, 0, 7, 0, 1);
    ins("R4", 40'h0_0000_0000, 0, 1, 0, 3, 0, 0, 0);
    look("R4", 40'h0_0080_0000, 0, 1, 0, 1);

    // R7: demap page
    demap("R7", 2, 40'h0_0001_0000, 0, 7, 0);
    look("R7", 40'h0_0001_0000, 0, 7, 0, 1);
    demap("R7", 2, 40'h0_3000_1234, 0, 3, 1);
    look("R7", 40'h0_3000_0000, 0, 5, 1, 1);

    // R5/R6: fill, locks and victim order
    for (int k = 0; k < N; k++)
      ins("R5", VA_W'(k + 64) << 13, 1, 2, 0, 0, (k < 2), 0, 0);
    for (int k = 0; k < 3; k++) look("R6", VA_W'(k + 66) << 13, 1, 2, 0, 1);
    ins("R5", VA_W'(200) << 13, 1, 2, 0, 0, 0, 0, 0);
    ins("R5", VA_W'(201) << 13, 1, 2, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++) look("R6", VA_W'(k + 64) << 13, 1, 2, 0, 1);
    ins("R6", VA_W'(202) << 13, 1, 2, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++) ins("R5", VA_W'(k + 300) << 13, 1, 3, 0, 0, 1, 1, k);
    ins("R5", VA_W'(400) << 13, 1, 3, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++) look("R5", VA_W'(k + 300) << 13, 1, 3, 0, 0);

    // R9: demap-all keeps locked entries
    ins("R9", VA_W'(500) << 13, 1, 4, 0, 0, 0, 1, 2);
    ins("R9", VA_W'(501) << 13, 1, 4, 0, 0, 0, 1, 5);
    demap("R9", 4, '0, 1, 0, 0);
    for (int k = 0; k < N; k++) look("R9", VA_W'(k + 300) << 13, 1, 3, 0, 0);
    demap("R9", 6, '0, 1, 3, 0);
    // R8: demap-context removes locked entries too
    demap("R8", 3, '0, 1, 3, 0);
    for (int k = 0; k < N; k++) look("R8", VA_W'(k + 300) << 13, 1, 3, 0, 0);

    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r;
      lkReq  = ($urandom % 2) == 0;
      lkVa   = (VA_W'($urandom % 24) << 13) | VA_W'($urandom % 8192);
      lkPart = PART_W'($urandom % 2);
      lkCtx  = CTX_W'($urandom % 3);
      lkReal = ($urandom % 4) == 0;
      r = $urandom % 40;
      cmdOp = (r < 12) ? 3'd1 : (r < 15) ? 3'd2 : (r < 17) ? 3'd3 :
              (r == 17) ? 3'd4 : (r == 18) ? 3'd6 : 3'd0;
      cmdVa     = (VA_W'($urandom % 24) << 13) | VA_W'($urandom % 8192);
      cmdPart   = PART_W'($urandom % 2);
      cmdCtx    = CTX_W'($urandom % 3);
      cmdReal   = ($urandom % 4) == 0;
      cmdSize   = (($urandom % 10) == 0) ? 2'(1 + $urandom % 2) : 2'd0;
      cmdLock   = ($urandom % 6) == 0;
      cmdData   = {$urandom, $urandom};
      cmdUseIdx = ($urandom % 5) == 0;
      cmdIdx    = IDX_W'($urandom % N);
      step("R2");
    end
    cmdOp = 0;
    step("R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule